// File: doc/BRIEF.md
# Banked Register File Address Unit

This unit turns the short register field of an 8-bit core's instructions into a full 9-bit data-memory address. The register file is split into four banks of 128 bytes. A direct access places two bank-select bits from the status register above the 7-bit field. An access to offset 00h names a virtual register that has no storage. That access is redirected through an 8-bit pointer register, with one more status bit placed above the pointer to reach the upper two banks.

The pointer register is held inside the unit. It is mapped at offset 04h of every bank, so software can load it or read it whatever the bank bits are. When an indirect access points back at offset 00h, a read returns zero and a write is dropped. All outputs toward the RAM, and the read data returned to the core, are combinational in the request cycle. A pointer write takes effect on the next clock edge.

Top module: `bank_addr_unit`

## Requirements
- R1: For a request whose field is not 00h, `ram_addr_o` equals {`bank_i[1:0]`, `ofs_i[6:0]`}, so banks 0..3 cover 000h-07Fh, 080h-0FFh, 100h-17Fh and 180h-1FFh.
- R2: For a request whose field is 00h, `ram_addr_o` equals {`bank_hi_i`, pointer[7:0]}.
- R3: A read through offset 00h while pointer[6:0] is zero returns 00h on `rdata_o`, whatever `ram_rdata_i` holds.
- R4: A write through offset 00h while pointer[6:0] is zero leaves `ram_we_o` low and the pointer unchanged.
- R5: A write whose resolved offset (`ram_addr_o[6:0]`) is 04h loads `wdata_i` into the pointer at the next rising edge, in every bank, and leaves `ram_we_o` low.
- R6: A read whose resolved offset is 04h returns the pointer on `rdata_o`. Any other read that is not covered by R3 returns `ram_rdata_i`.
- R7: `ram_we_o` is high only during a request with `we_i` high. Any other write request drives it high in the same cycle, with `ram_wdata_o` equal to `wdata_i`.
- R8: After reset, the pointer reads as 00h.
- R9: Loading the pointer with 20h, then incrementing it and stopping once bit 4 is set, writes exactly the 16 locations 20h to 2Fh through offset 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| ofs_i | input | 7 | Register field from the opcode |
| wdata_i | input | 8 | Write data from the core |
| bank_i | input | 2 | Direct bank-select bits |
| bank_hi_i | input | 1 | Upper address bit for indirect access |
| ram_rdata_i | input | 8 | Read data from the RAM |
| ram_addr_o | output | 9 | Resolved RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | RAM write data |
| rdata_o | output | 8 | Read data returned to the core |

## Verification
Address, write enable and read data depend only on the inputs and the pointer, so each check samples them one nanosecond after the inputs are driven at a falling edge, within the same cycle. A pointer load becomes visible only after the next rising edge. The bench therefore reads the pointer back through offset 04h in the following cycle, and never earlier. Dropped writes are observed both at `ram_we_o` in their own cycle and through a pointer readback in the next cycle.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  parameter int unsigned OFS_W   = 7;
  parameter int unsigned BANK_W  = 2;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned IND_OFS = 0;
  parameter int unsigned PTR_OFS = 4;
  localparam int unsigned ADDR_W = BANK_W + OFS_W;

  typedef enum logic [1:0] {
    SEL_RAM  = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_ZERO = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/bank_addr_resolve.sv
module bank_addr_resolve
  import bank_addr_pkg::*;
#(
  parameter int unsigned OfsW   = OFS_W,
  parameter int unsigned BankW  = BANK_W,
  parameter int unsigned DataW  = DATA_W,
  parameter int unsigned IndOfs = IND_OFS,
  parameter int unsigned PtrOfs = PTR_OFS,
  localparam int unsigned AddrW = BankW + OfsW
) (
  input  logic [OfsW-1:0]  ofs_i,
  input  logic [BankW-1:0] bank_i,
  input  logic             bank_hi_i,
  input  logic [DataW-1:0] ptr_i,
  output logic [AddrW-1:0] addr_o,
  output logic             null_o,
  output logic             ptr_hit_o
);
  logic ind;

  assign ind = (ofs_i == OfsW'(IndOfs));

  // indirect: upper bank bit above full pointer
  assign addr_o    = ind ? AddrW'({bank_hi_i, ptr_i}) : {bank_i, ofs_i};
  assign null_o    = ind && (ptr_i[OfsW-1:0] == OfsW'(IndOfs));
  assign ptr_hit_o = (addr_o[OfsW-1:0] == OfsW'(PtrOfs));
endmodule

// File: rtl/bank_ptr_reg.sv
module bank_ptr_reg
  import bank_addr_pkg::*;
#(
  parameter int unsigned DataW = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DataW-1:0] wdata_i,
  output logic [DataW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= wdata_i;
  end
endmodule

// File: rtl/bank_rd_mux.sv
module bank_rd_mux
  import bank_addr_pkg::*;
#(
  parameter int unsigned DataW = DATA_W
) (
  input  rd_sel_e          sel_i,
  input  logic [DataW-1:0] ptr_i,
  input  logic [DataW-1:0] ram_rdata_i,
  output logic [DataW-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      SEL_PTR:  rdata_o = ptr_i;
      SEL_ZERO: rdata_o = '0;
      default:  rdata_o = ram_rdata_i;
    endcase
  end
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
  import bank_addr_pkg::*;
#(
  parameter int unsigned OfsW   = OFS_W,
  parameter int unsigned BankW  = BANK_W,
  parameter int unsigned DataW  = DATA_W,
  parameter int unsigned IndOfs = IND_OFS,
  parameter int unsigned PtrOfs = PTR_OFS,
  localparam int unsigned AddrW = BankW + OfsW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [OfsW-1:0]  ofs_i,
  input  logic [DataW-1:0] wdata_i,
  input  logic [BankW-1:0] bank_i,
  input  logic             bank_hi_i,
  input  logic [DataW-1:0] ram_rdata_i,
  output logic [AddrW-1:0] ram_addr_o,
  output logic             ram_we_o,
  output logic [DataW-1:0] ram_wdata_o,
  output logic [DataW-1:0] rdata_o
);
  logic [DataW-1:0] ptr_q;
  logic             null_acc;
  logic             ptr_hit;
  logic             wr;
  rd_sel_e          rd_sel;

  bank_addr_resolve #(
    .OfsW(OfsW), .BankW(BankW), .DataW(DataW), .IndOfs(IndOfs), .PtrOfs(PtrOfs)
  ) i_resolve (
    .ofs_i     (ofs_i),
    .bank_i    (bank_i),
    .bank_hi_i (bank_hi_i),
    .ptr_i     (ptr_q),
    .addr_o    (ram_addr_o),
    .null_o    (null_acc),
    .ptr_hit_o (ptr_hit)
  );

  assign wr = req_i && we_i && !null_acc;

  bank_ptr_reg #(.DataW(DataW)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wr && ptr_hit),
    .wdata_i (wdata_i),
    .ptr_o   (ptr_q)
  );

  assign ram_we_o    = wr && !ptr_hit;
  assign ram_wdata_o = wdata_i;

  always_comb begin
    if (null_acc)     rd_sel = SEL_ZERO;
    else if (ptr_hit) rd_sel = SEL_PTR;
    else              rd_sel = SEL_RAM;
  end

  bank_rd_mux #(.DataW(DataW)) i_rd_mux (
    .sel_i       (rd_sel),
    .ptr_i       (ptr_q),
    .ram_rdata_i (ram_rdata_i),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/bank_addr_unit_chk.sv
module bank_addr_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [6:0] ofs_i,
  input logic [7:0] wdata_i,
  input logic [1:0] bank_i,
  input logic       bank_hi_i,
  input logic [8:0] ram_addr_o,
  input logic       ram_we_o,
  input logic [7:0] rdata_o,
  input logic [7:0] ptr_q
);
  a_r1_direct_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ofs_i != 7'd0) |-> ram_addr_o == {bank_i, ofs_i});

  a_r2_indirect_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ofs_i == 7'd0) |-> ram_addr_o == {bank_hi_i, ptr_q});

  a_r3_null_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && ofs_i == 7'd0 && ptr_q[6:0] == 7'd0) |-> rdata_o == 8'h00);

  a_r4_null_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ofs_i == 7'd0 && ptr_q[6:0] == 7'd0) |-> !ram_we_o);

  a_r5_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ram_addr_o[6:0] == 7'd4 && ofs_i != 7'd0)
      |=> ptr_q == $past(wdata_i));

  a_r5_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && ram_addr_o[6:0] == 7'd4) |=> $stable(ptr_q));

  a_r7_no_req_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |-> !ram_we_o);
endmodule

bind bank_addr_unit bank_addr_unit_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .ofs_i      (ofs_i),
  .wdata_i    (wdata_i),
  .bank_i     (bank_i),
  .bank_hi_i  (bank_hi_i),
  .ram_addr_o (ram_addr_o),
  .ram_we_o   (ram_we_o),
  .rdata_o    (rdata_o),
  .ptr_q      (ptr_q)
);

// File: tb/test_bank_addr_unit.sv
`timescale 1ns/1ps
module test_bank_addr_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [6:0] ofs_i = '0;
  logic [7:0] wdata_i = '0;
  logic [1:0] bank_i = '0;
  logic       bank_hi_i = 1'b0;
  logic [7:0] ram_rdata_i = 8'hA5;
  logic [8:0] ram_addr_o;
  logic       ram_we_o;
  logic [7:0] ram_wdata_o;
  logic [7:0] rdata_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bank_addr_unit i_bank_addr_unit (
    .clk_i, .rst_ni, .req_i, .we_i, .ofs_i, .wdata_i, .bank_i, .bank_hi_i,
    .ram_rdata_i, .ram_addr_o, .ram_we_o, .ram_wdata_o, .rdata_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns later
  task automatic drive(input bit rq, input bit w, input logic [6:0] o, input logic [7:0] d);
    @(negedge clk_i);
    req_i = rq; we_i = w; ofs_i = o; wdata_i = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] v);
    drive(1, 1, 7'h04, v);
    idle();
  endtask

  task automatic read_ptr(output logic [7:0] v);
    drive(1, 0, 7'h04, 8'h00);
    v = rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] p;
    bank_i = 2'd3;
    read_ptr(p);
    chk(p == 8'h00, "R8 ptr after reset", p, 0);
    idle();
  endtask

  task automatic t_direct();
    for (int b = 0; b < 4; b++) begin
      bank_i = b[1:0];
      drive(1, 0, 7'h35, 8'h00);
      chk(ram_addr_o == 9'(b * 128 + 'h35), "R1 direct addr", ram_addr_o, b * 128 + 'h35);
      chk(rdata_o == 8'hA5, "R6 ram passthrough", rdata_o, 'hA5);
    end
    bank_i = 2'd2;
    drive(1, 0, 7'h7F, 8'h00);
    chk(ram_addr_o == 9'h17F, "R1 bank2 top", ram_addr_o, 'h17F);
    drive(1, 1, 7'h10, 8'h3C);
    chk(ram_we_o && ram_wdata_o == 8'h3C, "R7 write passes", {ram_we_o, ram_wdata_o}, 'h13C);
    drive(0, 1, 7'h10, 8'h3C);
    chk(!ram_we_o, "R7 no req no we", ram_we_o, 0);
    idle();
  endtask

  task automatic t_ptr_every_bank();
    logic [7:0] p;
    for (int b = 0; b < 4; b++) begin
      bank_i = b[1:0];
      drive(1, 1, 7'h04, 8'h40 + 8'(b));
      chk(!ram_we_o, "R5 no ram we on ptr write", ram_we_o, 0);
      read_ptr(p);
      chk(p == 8'h40 + 8'(b), "R5 ptr load in bank", p, 'h40 + b);
      chk(rdata_o != 8'hA5, "R6 ptr read not ram", rdata_o, 'h40 + b);
    end
    idle();
  endtask

  task automatic t_indirect();
    set_ptr(8'hC3);
    bank_hi_i = 1'b1;
    drive(1, 0, 7'h00, 8'h00);
    chk(ram_addr_o == 9'h1C3, "R2 indirect hi", ram_addr_o, 'h1C3);
    bank_hi_i = 1'b0;
    drive(1, 0, 7'h00, 8'h00);
    chk(ram_addr_o == 9'h0C3, "R2 indirect lo", ram_addr_o, 'h0C3);
    drive(1, 1, 7'h00, 8'h77);
    chk(ram_we_o, "R7 indirect write enable", ram_we_o, 1);
    idle();
  endtask

  task automatic t_null();
    logic [7:0] p;
    set_ptr(8'h00);
    ram_rdata_i = 8'h5A;
    drive(1, 0, 7'h00, 8'h00);
    chk(rdata_o == 8'h00, "R3 null read zero", rdata_o, 0);
    drive(1, 1, 7'h00, 8'h99);
    chk(!ram_we_o, "R4 null write dropped", ram_we_o, 0);
    read_ptr(p);
    chk(p == 8'h00, "R4 ptr unchanged", p, 0);
    set_ptr(8'h80);
    drive(1, 1, 7'h00, 8'h99);
    chk(!ram_we_o, "R4 null write ptr 80h", ram_we_o, 0);
    drive(1, 0, 7'h00, 8'h00);
    chk(rdata_o == 8'h00, "R3 null read ptr 80h", rdata_o, 0);
    ram_rdata_i = 8'hA5;
    idle();
  endtask

  task automatic t_walk();
    logic [7:0] p;
    int writes = 0;
    bit order_ok = 1'b1;
    bank_hi_i = 1'b0;
    set_ptr(8'h20);
    for (int i = 0; i < 40; i++) begin
      drive(1, 1, 7'h00, 8'h00);
      if (ram_we_o) begin
        if (ram_addr_o != 9'(8'h20 + 8'(writes))) order_ok = 1'b0;
        writes++;
      end
      read_ptr(p);
      set_ptr(p + 8'h01);
      if (p[4] == 1'b0 && ((p + 8'h01) & 8'h10) != 0) break;
    end
    chk(writes == 16, "R9 walk count", writes, 16);
    chk(order_ok, "R9 walk order", order_ok, 1);
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    t_reset();
    t_direct();
    t_ptr_every_bank();
    t_indirect();
    t_null();
    t_walk();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule